// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the control logic of a byte-wide parallel NOR-style flash device. It watches the asynchronous chip-enable, output-enable and write-enable strobes and decodes multi-write unlock sequences. The recognised commands are byte program, chip erase, product-ID entry and exit, and a permanent lockout of the lowest region of the array. Program and erase run for a parameterised number of clock cycles. While an operation runs, reads return status bits in place of array data. The array is a small behavioural register file inside the block. It is indexed by the low `MEM_AW` address bits, and its protected region is the lowest `2**BOOT_AW` bytes.

The bus pins are asynchronous to `clk_i`. The control strobes, address and data are carried together through one synchroniser, so a write is judged on one consistent sample of the bus. Each write cycle is reduced to a single strobe that carries its address and data. A sequence step that does not match drops the decoder back to read mode without touching the array.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset every byte reads FF, the protected region is unlocked, the device is in read mode and no operation is running.
- R2: `data_oe_o` is 1 exactly when `ce_ni` and `oe_ni` are both 0. In read mode with no operation running, `data_o` is the stored byte at array index `addr_i[MEM_AW-1:0]`.
- R3: Every command opens with data AA at address 5555 followed by data 55 at address 2AAA. Only address bits 14..0 are compared. A write that does not match the expected step returns the decoder to read mode and leaves the array unchanged.
- R4: Byte program is the unlock pair, then A0 at 5555, then a write of the target address and data. The stored byte becomes the old value AND the new data, and the operation stays busy for `PGM_CYC` cycles.
- R5: While busy, a read returns bit 7 as the complement of bit 7 of the loaded program data (0 during erase), bit 6 inverted from the previous busy read, and bits 5..0 from the array. True data returns once the operation ends.
- R6: Chip erase is AA, 55, 80, AA, 55, 10 written to 5555, 2AAA, 5555, 5555, 2AAA, 5555. It sets every byte outside a locked region to FF and stays busy for `ERS_CYC` cycles.
- R7: The same six-write pattern ending in 40 instead of 10 locks the lowest `2**BOOT_AW` bytes. From then until reset, those bytes are neither programmed nor erased, and a program to them starts no operation.
- R8: Unlock pair then 90 at 5555 enters ID mode. There, full address 0 reads 1F, address 1 reads 0B, address 2 reads the lock flag on bit 0 (1 = locked) and other addresses read 00.
- R9: ID mode ends on a single write of F0 to any address, or on the unlock pair followed by F0 at 5555. A write of F0 outside the program data step also resets the sequence.
- R10: A write counts only when both `ce_ni` and `we_ni` have been 0 with `oe_ni` 1 and the cycle ends by `ce_ni` or `we_ni` rising. The address is taken when the write becomes active. The data is taken when it ends. A cycle cut short by `oe_ni` falling is ignored.
- R11: Writes that arrive while an operation is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | A_W | Byte address |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data toward the bus |
| data_oe_o | output | 1 | Drive enable for `data_o` |

## Verification
A decoder stuck in a wrong step shows up at the next command. A program or erase then either fails to change the array, or changes it when it should not, and a read after the busy window shows it. A wrong busy, poll or toggle state appears on the very next read, as a bit 7 or bit 6 that does not match the loaded data or the previous read. A lost or spurious lock flag appears in the ID-mode lock byte and in the final sweep over every array index, which is compared against a model the bench keeps arithmetically.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] ADR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_B = 15'h2AAA;

  localparam logic [7:0] K_UNLK1   = 8'hAA;
  localparam logic [7:0] K_UNLK2   = 8'h55;
  localparam logic [7:0] K_PGM     = 8'hA0;
  localparam logic [7:0] K_ERS_PRE = 8'h80;
  localparam logic [7:0] K_ERS     = 8'h10;
  localparam logic [7:0] K_LOCK    = 8'h40;
  localparam logic [7:0] K_ID      = 8'h90;
  localparam logic [7:0] K_EXIT    = 8'hF0;

  localparam logic [7:0] ID_MFR = 8'h1F;
  localparam logic [7:0] ID_DEV = 8'h0B;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_LOAD, S_E1, S_E2, S_E3
  } seq_e;
endpackage

// File: rtl/nor_bus_sync.sv
module nor_bus_sync #(
  parameter int AW     = 15,
  parameter int SYNC_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_rise_o
);
  localparam int BW = 3 + AW + 8;
  localparam logic [BW-1:0] BUS_IDLE = {3'b111, {(AW+8){1'b0}}};

  logic [BW-1:0] pipe_q [SYNC_N];

  // whole bundle goes through the same stages so strobes and payload stay aligned
  for (genvar s = 0; s < SYNC_N; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= BUS_IDLE;
      else if (s == 0) pipe_q[s] <= {ce_ni, oe_ni, we_ni, addr_i, data_i};
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  logic          s_ce_n, s_oe_n, s_we_n;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_data;
  assign {s_ce_n, s_oe_n, s_we_n, s_addr, s_data} = pipe_q[SYNC_N-1];

  logic wr_act, rd_act, wr_act_q, rd_act_q;
  logic [AW-1:0] addr_q;

  assign wr_act = !s_ce_n && !s_we_n && s_oe_n;
  assign rd_act = !s_ce_n && !s_oe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act && !wr_act_q) addr_q <= s_addr;
    end
  end

  // end of write counts only if OE is still high (ended by CE or WE rising)
  assign wr_stb_o  = wr_act_q && !wr_act && s_oe_n;
  assign wr_addr_o = addr_q;
  assign wr_data_o = s_data;
  assign rd_rise_o = rd_act && !rd_act_q;
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int MEM_AW  = 8,
  parameter int BOOT_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [CMD_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              busy_i,
  input  logic              lock_i,
  output logic              pgm_go_o,
  output logic              erase_go_o,
  output logic              lock_go_o,
  output logic [MEM_AW-1:0] pgm_idx_o,
  output logic [7:0]        pgm_data_o,
  output logic              id_mode_o
);
  seq_e st_q, st_d;
  logic id_q, id_d, pgm_d, ers_d, lck_d;
  logic [MEM_AW-1:0] idx_d;
  logic [7:0] dat_d;
  logic at_a, at_b, in_boot;

  assign at_a    = (wr_addr_i == ADR_A);
  assign at_b    = (wr_addr_i == ADR_B);
  assign in_boot = ~|wr_addr_i[MEM_AW-1:BOOT_AW];

  always_comb begin
    st_d  = st_q;
    id_d  = id_q;
    pgm_d = 1'b0;
    ers_d = 1'b0;
    lck_d = 1'b0;
    idx_d = pgm_idx_o;
    dat_d = pgm_data_o;
    if (wr_stb_i && !busy_i) begin
      if (st_q != S_LOAD && wr_data_i == K_EXIT) begin
        st_d = S_IDLE;
        id_d = 1'b0;
      end else begin
        st_d = S_IDLE;
        case (st_q)
          S_IDLE: if (at_a && wr_data_i == K_UNLK1) st_d = S_U1;
          S_U1:   if (at_b && wr_data_i == K_UNLK2) st_d = S_U2;
          S_U2: if (at_a) begin
            if (wr_data_i == K_PGM)     st_d = S_LOAD;
            if (wr_data_i == K_ERS_PRE) st_d = S_E1;
            if (wr_data_i == K_ID)      id_d = 1'b1;
          end
          S_LOAD: if (!(lock_i && in_boot)) begin
            pgm_d = 1'b1;
            idx_d = wr_addr_i[MEM_AW-1:0];
            dat_d = wr_data_i;
          end
          S_E1: if (at_a && wr_data_i == K_UNLK1) st_d = S_E2;
          S_E2: if (at_b && wr_data_i == K_UNLK2) st_d = S_E3;
          S_E3: if (at_a) begin
            ers_d = (wr_data_i == K_ERS);
            lck_d = (wr_data_i == K_LOCK);
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      id_q       <= 1'b0;
      pgm_go_o   <= 1'b0;
      erase_go_o <= 1'b0;
      lock_go_o  <= 1'b0;
      pgm_idx_o  <= '0;
      pgm_data_o <= '0;
    end else begin
      st_q       <= st_d;
      id_q       <= id_d;
      pgm_go_o   <= pgm_d;
      erase_go_o <= ers_d;
      lock_go_o  <= lck_d;
      pgm_idx_o  <= idx_d;
      pgm_data_o <= dat_d;
    end
  end

  assign id_mode_o = id_q;
endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
  parameter int PGM_CYC = 20,
  parameter int ERS_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pgm_i,
  input  logic start_ers_i,
  output logic busy_o
);
  localparam int MAXC = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_ers_i)   cnt_q <= CW'(ERS_CYC);
    else if (start_pgm_i)   cnt_q <= CW'(PGM_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
  parameter int MEM_AW  = 8,
  parameter int BOOT_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_go_i,
  input  logic [MEM_AW-1:0] pgm_idx_i,
  input  logic [7:0]        pgm_data_i,
  input  logic              erase_go_i,
  input  logic              lock_go_i,
  input  logic [MEM_AW-1:0] rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic              lock_o
);
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int BOOT_N = 1 << BOOT_AW;

  logic       lock_q;
  logic [7:0] rd_vec [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= 1'b0;
    else if (lock_go_i) lock_q <= 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam bit IS_BOOT = (i < BOOT_N);
    logic [7:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cell_q <= 8'hFF;
      else if (erase_go_i && !(IS_BOOT && lock_q))
        cell_q <= 8'hFF;
      else if (pgm_go_i && pgm_idx_i == MEM_AW'(i))
        cell_q <= cell_q & pgm_data_i;
    end
    assign rd_vec[i] = cell_q;
  end

  assign rd_data_o = rd_vec[rd_idx_i];
  assign lock_o    = lock_q;
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int A_W     = 18,
  parameter int MEM_AW  = 8,
  parameter int BOOT_AW = 5,
  parameter int SYNC_N  = 2,
  parameter int PGM_CYC = 20,
  parameter int ERS_CYC = 60
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ce_ni,
  input  logic           oe_ni,
  input  logic           we_ni,
  input  logic [A_W-1:0] addr_i,
  input  logic [7:0]     data_i,
  output logic [7:0]     data_o,
  output logic           data_oe_o
);
  logic              wr_stb, rd_rise;
  logic [CMD_AW-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              busy, lock, id_mode;
  logic              pgm_go, erase_go, lock_go;
  logic [MEM_AW-1:0] pgm_idx;
  logic [7:0]        pgm_data, arr_rd;
  logic              tog_q, poll_q;

  nor_bus_sync #(.AW(CMD_AW), .SYNC_N(SYNC_N)) i_bus (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .addr_i   (addr_i[CMD_AW-1:0]),
    .data_i,
    .wr_stb_o (wr_stb),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .rd_rise_o(rd_rise)
  );

  nor_seq_fsm #(.MEM_AW(MEM_AW), .BOOT_AW(BOOT_AW)) i_fsm (
    .clk_i, .rst_ni,
    .wr_stb_i  (wr_stb),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .busy_i    (busy),
    .lock_i    (lock),
    .pgm_go_o  (pgm_go),
    .erase_go_o(erase_go),
    .lock_go_o (lock_go),
    .pgm_idx_o (pgm_idx),
    .pgm_data_o(pgm_data),
    .id_mode_o (id_mode)
  );

  nor_op_timer #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) i_timer (
    .clk_i, .rst_ni,
    .start_pgm_i(pgm_go),
    .start_ers_i(erase_go),
    .busy_o     (busy)
  );

  nor_byte_array #(.MEM_AW(MEM_AW), .BOOT_AW(BOOT_AW)) i_array (
    .clk_i, .rst_ni,
    .pgm_go_i  (pgm_go),
    .pgm_idx_i (pgm_idx),
    .pgm_data_i(pgm_data),
    .erase_go_i(erase_go),
    .lock_go_i (lock_go),
    .rd_idx_i  (addr_i[MEM_AW-1:0]),
    .rd_data_o (arr_rd),
    .lock_o    (lock)
  );

  // status bits for busy reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      if (rd_rise && busy) tog_q <= ~tog_q;
      if (pgm_go)          poll_q <= pgm_data[7];
      else if (erase_go)   poll_q <= 1'b1;
    end
  end

  always_comb begin
    if (busy)
      data_o = {~poll_q, tog_q, arr_rd[5:0]};
    else if (id_mode) begin
      if (addr_i == A_W'(0))      data_o = ID_MFR;
      else if (addr_i == A_W'(1)) data_o = ID_DEV;
      else if (addr_i == A_W'(2)) data_o = {7'b0, lock};
      else                        data_o = 8'h00;
    end else
      data_o = arr_rd;
  end

  assign data_oe_o = !ce_ni && !oe_ni;
endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
  parameter int MEM_AW  = 8,
  parameter int BOOT_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              pgm_go,
  input logic              erase_go,
  input logic              lock_go,
  input logic              lock,
  input logic [MEM_AW-1:0] pgm_idx,
  input logic              tog_q,
  input logic              rd_rise
);
  a_r11_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_go || erase_go) |-> !busy);

  a_r4_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(pgm_go || erase_go));

  a_r5_tog_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_rise) |=> (tog_q != $past(tog_q)));

  a_r6_one_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pgm_go, erase_go, lock_go}));

  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> lock);

  a_r7_boot_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_go && lock) |-> (|pgm_idx[MEM_AW-1:BOOT_AW]));
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.MEM_AW(MEM_AW), .BOOT_AW(BOOT_AW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy    (busy),
  .pgm_go  (pgm_go),
  .erase_go(erase_go),
  .lock_go (lock_go),
  .lock    (lock),
  .pgm_idx (pgm_idx),
  .tog_q   (tog_q),
  .rd_rise (rd_rise)
);

// File: tb/test_nor_cmd_ctrl.sv
module test_nor_cmd_ctrl;
  localparam int PGM = 40;
  localparam int ERS = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [256];
  logic       lk = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_ctrl #(.A_W(18), .MEM_AW(8), .BOOT_AW(5), .SYNC_N(2),
                 .PGM_CYC(PGM), .ERS_CYC(ERS)) i_nor_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(dout_en)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [17:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    v = dout;
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic bit prot(input logic [17:0] a);
    return lk && (a[7:0] < 8'd32);
  endfunction

  task automatic prog_start(input logic [17:0] a, input logic [7:0] d);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(a, d);
    if (!prot(a)) exp_q[a[7:0]] = exp_q[a[7:0]] & d;
  endtask

  task automatic prog(input logic [17:0] a, input logic [7:0] d);
    prog_start(a, d);
    repeat (PGM + 10) @(negedge clk);
  endtask

  task automatic six(input logic [7:0] last);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, last);
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      rd(18'(i), v);
      check(tag, v, exp_q[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    for (int i = 0; i < 256; i++) exp_q[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 drive enable
    ce_n = 1'b0; oe_n = 1'b1; @(posedge clk); #1 check("R2 oe high", {7'b0, dout_en}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0; @(posedge clk); #1 check("R2 ce high", {7'b0, dout_en}, 8'h00);
    ce_n = 1'b0; oe_n = 1'b0; @(posedge clk); #1 check("R2 both low", {7'b0, dout_en}, 8'h01);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; repeat (3) @(negedge clk);

    // R1 reset state, all bytes erased
    sweep("R1 reset contents");

    // R4 program AND semantics
    prog(18'h00040, 8'h3C); rd(18'h00040, v); check("R4 first program", v, 8'h3C);
    prog(18'h00040, 8'hF5); rd(18'h00040, v); check("R4 and with old", v, 8'h34);

    // R5 status reads during program
    prog_start(18'h00050, 8'h81);
    rd(18'h00050, v); rd(18'h00050, v2);
    check("R5 poll bit7", {7'b0, v[7]}, 8'h00);
    check("R5 low bits", {2'b0, v[5:0]}, 8'h01);
    check("R5 bit6 toggles", {7'b0, v[6] ^ v2[6]}, 8'h01);
    repeat (PGM + 10) @(negedge clk);
    rd(18'h00050, v); check("R5 true data after", v, 8'h81);

    // R3 broken sequences
    wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00070, 8'h00);
    repeat (PGM + 10) @(negedge clk);
    rd(18'h00070, v); check("R3 bad unlock addr", v, 8'hFF);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h77);
    wr(18'h05555, 8'hA0); wr(18'h00071, 8'h00);
    repeat (PGM + 10) @(negedge clk);
    rd(18'h00071, v); check("R3 unknown command", v, 8'hFF);
    wr(18'h3D555, 8'hAA); wr(18'h3AAAA, 8'h55); wr(18'h35555, 8'hA0); wr(18'h00072, 8'h5A);
    exp_q[8'h72] = 8'h5A;
    repeat (PGM + 10) @(negedge clk);
    rd(18'h00072, v); check("R3 upper bits ignored", v, 8'h5A);

    // R10 write aborted by OE falling
    @(negedge clk);
    addr = 18'h05555; din = 8'hAA; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk); oe_n = 1'b0;
    repeat (3) @(negedge clk); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00080, 8'h00);
    repeat (PGM + 10) @(negedge clk);
    rd(18'h00080, v); check("R10 oe abort ignored", v, 8'hFF);
    // R10 address at start, data at end
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
    @(negedge clk);
    addr = 18'h00090; din = 8'h22; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk); addr = 18'h00091; din = 8'h11;
    repeat (3) @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_q[8'h90] = 8'h11;
    repeat (PGM + 10) @(negedge clk);
    rd(18'h00090, v); check("R10 start address", v, 8'h11);
    rd(18'h00091, v); check("R10 other address", v, 8'hFF);

    // R8 ID mode
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
    rd(18'h00000, v); check("R8 maker code", v, 8'h1F);
    rd(18'h00001, v); check("R8 device code", v, 8'h0B);
    rd(18'h00002, v); check("R8 unlocked flag", v, 8'h00);
    rd(18'h00003, v); check("R8 other id addr", v, 8'h00);

    // R9 exits
    wr(18'h00123, 8'hF0);
    rd(18'h00000, v); check("R9 single F0 exit", v, 8'hFF);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hF0);
    rd(18'h00001, v); check("R9 unlock F0 exit", v, 8'hFF);
    rd(18'h00040, v); check("R9 array readable", v, 8'h34);

    // R7 lockout
    prog(18'h00005, 8'h0F);
    six(8'h40); lk = 1'b1;
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
    rd(18'h00002, v); check("R7 lock flag", v, 8'h01);
    wr(18'h00000, 8'hF0);
    prog(18'h00005, 8'h00); rd(18'h00005, v); check("R7 boot program blocked", v, 8'h0F);
    prog_start(18'h0001F, 8'h00);
    rd(18'h0001F, v); check("R7 no busy on blocked", v, 8'hFF);
    prog(18'h00020, 8'h00); rd(18'h00020, v); check("R7 first main byte", v, 8'h00);

    // R6 erase, R5 status during erase, R11 writes while busy
    six(8'h10);
    rd(18'h00040, v); check("R5 erase poll bit7", {7'b0, v[7]}, 8'h00);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00060, 8'h00);
    for (int i = 0; i < 256; i++) if (!prot(18'(i))) exp_q[i] = 8'hFF;
    repeat (ERS + 20) @(negedge clk);
    rd(18'h00060, v); check("R11 busy write ignored", v, 8'hFF);
    sweep("R6 R7 erase contents");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule